// File: doc/BRIEF.md
# Boot Region Write-Protection Controller

This block sits between a flash command decoder and the erase/program timing engine of a 256K-word array. For each requested operation it decides whether that operation may go ahead and, if so, which word range it covers. The operation is a single-word program, an erase of a 2K-word page, an erase of a block from the non-uniform block map, or a whole-array erase. The array contents are not held here. Only the decision and the range are produced.

It holds a sticky protection flag for the lowest 8K words of the array, the boot region. A strobe sets the flag. An ordinary reset does not clear it; only the power-on input does. While the flag is set, any program, page erase or block erase aimed into the boot region is dropped. The block still returns a completion pulse, with the accept bit low and no range. A whole-array erase is never dropped: with protection active its range starts just above the boot region. A high-voltage override input suspends protection for exactly the cycles in which it is held. The flag is also brought out as a status bit for identification readback, where it appears as bit 0 of the word at identification address 2.

Top module: `bootlock_guard`

## Requirements
- R1: While `rst` or `por` is high at a clock edge, `done_o`, `accept_o`, `range_start_o` and `range_end_o` are 0 after that edge, and any request in that cycle is discarded.
- R2: A `lock_set_i` pulse with `rst` and `por` low makes `lock_status_o` 1 from the next edge onward. Only `por` returns it to 0. `rst` neither clears it nor lets a strobe set it.
- R3: An accepted word program (`req_op_i` = 0) reports `range_start_o` = `range_end_o` = the request address.
- R4: An accepted page erase (`req_op_i` = 1) covers the 2K-word page selected by address bits [17:11]: start = address with bits [10:0] cleared, end = start + 0x7FF.
- R5: An accepted block erase (`req_op_i` = 2) covers one block of the map. The map is 0x00000–0x01FFF (boot), 0x02000–0x02FFF, 0x03000–0x03FFF, 0x04000–0x07FFF, then seven 32K-word blocks aligned on 0x8000 up to 0x3FFFF.
- R6: With the flag set and the override low, a program, page erase or block erase whose address is below 0x02000 yields `done_o` = 1, `accept_o` = 0 and both range outputs 0. Addresses from 0x02000 upward are accepted.
- R7: A chip erase (`req_op_i` = 3) is always accepted with end 0x3FFFF. Its start is 0x02000 when the flag is set and the override is low, and 0x00000 otherwise.
- R8: The override counts only in the cycle in which the request is presented. A boot-region request in the first cycle after the override drops is rejected again.
- R9: A request presented in the same cycle as a `lock_set_i` pulse is judged against the flag value before that pulse.
- R10: `done_o` is high for exactly one cycle, the cycle after each request taken outside reset, and is low otherwise. The outputs of a request appear on the edge at which it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; leaves the protection flag intact |
| por | input | 1 | Synchronous active-high power-on clear; also clears the protection flag |
| req_valid_i | input | 1 | A request is presented this cycle |
| req_op_i | input | 2 | 0 program, 1 page erase, 2 block erase, 3 chip erase |
| req_addr_i | input | 18 | Target word address |
| lock_set_i | input | 1 | Strobe that sets the boot protection flag |
| hv_override_i | input | 1 | High-voltage override; suspends protection while high |
| done_o | output | 1 | One-cycle completion of a decision |
| accept_o | output | 1 | Decision: 1 go ahead, 0 dropped |
| range_start_o | output | 18 | First word address to touch |
| range_end_o | output | 18 | Last word address to touch |
| lock_status_o | output | 1 | Protection flag, for identification readback bit 0 |

## Verification
Two functions can meet in one cycle: setting the flag and judging a request against it. A third collision is a request while the override changes. The bench raises `lock_set_i` in the same cycle as a program into the boot region and expects it to be accepted. It then expects the identical request in the next cycle to be dropped, with `lock_status_o` already reading 1. For the override, a boot-region program and a chip erase are issued while it is held. The same program is then issued in the first cycle after release and must be rejected.

// File: rtl/bootlock_pkg.sv
package bootlock_pkg;
  typedef enum logic [1:0] {
    OP_PROG  = 2'd0,
    OP_PAGE  = 2'd1,
    OP_BLOCK = 2'd2,
    OP_CHIP  = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    BC_BOOT  = 2'd0,
    BC_PARAM = 2'd1,
    BC_MID   = 2'd2,
    BC_MAIN  = 2'd3
  } blk_class_e;
endpackage

// File: rtl/bl_lock_flag.sv
module bl_lock_flag (
  input  logic clk,
  input  logic por,
  input  logic rst,
  input  logic set_i,
  output logic locked_o
);
  // Sticky flag: only power-on clears it, ordinary reset masks the strobe.
  always_ff @(posedge clk) begin
    if (por)
      locked_o <= 1'b0;
    else if (set_i && !rst)
      locked_o <= 1'b1;
  end
endmodule

// File: rtl/bl_region_map.sv
module bl_region_map
  import bootlock_pkg::*;
#(
  parameter int ADDR_W  = 18,
  parameter int PAGE_W  = 11,
  parameter int BOOT_W  = 13,
  parameter int PARAM_W = 12,
  parameter int MID_W   = 14,
  parameter int MAIN_W  = 15
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] page_lo_o,
  output logic [ADDR_W-1:0] page_hi_o,
  output logic [ADDR_W-1:0] blk_lo_o,
  output logic [ADDR_W-1:0] blk_hi_o,
  output logic              in_boot_o
);
  localparam logic [ADDR_W-1:0] ONE     = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] M_PAGE  = (ONE << PAGE_W)  - ONE;
  localparam logic [ADDR_W-1:0] M_BOOT  = (ONE << BOOT_W)  - ONE;
  localparam logic [ADDR_W-1:0] M_PARAM = (ONE << PARAM_W) - ONE;
  localparam logic [ADDR_W-1:0] M_MID   = (ONE << MID_W)   - ONE;
  localparam logic [ADDR_W-1:0] M_MAIN  = (ONE << MAIN_W)  - ONE;

  blk_class_e        cls;
  logic [ADDR_W-1:0] blk_mask;

  assign in_boot_o = (addr_i[ADDR_W-1:BOOT_W] == '0);

  // Uniform page: clear / fill the in-page offset bits.
  assign page_lo_o = addr_i & ~M_PAGE;
  assign page_hi_o = addr_i |  M_PAGE;

  // Non-uniform block map: class from the highest set region bit.
  always_comb begin
    if (addr_i[ADDR_W-1:MAIN_W] != '0)
      cls = BC_MAIN;
    else if (addr_i[MAIN_W-1:MID_W] != '0)
      cls = BC_MID;
    else if (addr_i[MID_W-1:BOOT_W] != '0)
      cls = BC_PARAM;
    else
      cls = BC_BOOT;

    case (cls)
      BC_MAIN:  blk_mask = M_MAIN;
      BC_MID:   blk_mask = M_MID;
      BC_PARAM: blk_mask = M_PARAM;
      default:  blk_mask = M_BOOT;
    endcase
  end

  assign blk_lo_o = addr_i & ~blk_mask;
  assign blk_hi_o = addr_i |  blk_mask;
endmodule

// File: rtl/bl_gate.sv
module bl_gate
  import bootlock_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int BOOT_W = 13
) (
  input  op_e               op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              locked_i,
  input  logic              hv_i,
  input  logic [ADDR_W-1:0] page_lo_i,
  input  logic [ADDR_W-1:0] page_hi_i,
  input  logic [ADDR_W-1:0] blk_lo_i,
  input  logic [ADDR_W-1:0] blk_hi_i,
  input  logic              in_boot_i,
  output logic              accept_o,
  output logic [ADDR_W-1:0] lo_o,
  output logic [ADDR_W-1:0] hi_o
);
  localparam logic [ADDR_W-1:0] BOOT_NEXT = ADDR_W'(1) << BOOT_W;

  logic              guard;
  logic [ADDR_W-1:0] lo_raw;
  logic [ADDR_W-1:0] hi_raw;

  assign guard = locked_i && !hv_i;

  always_comb begin
    accept_o = 1'b1;
    case (op_i)
      OP_PROG: begin
        lo_raw = addr_i;
        hi_raw = addr_i;
      end
      OP_PAGE: begin
        lo_raw = page_lo_i;
        hi_raw = page_hi_i;
      end
      OP_BLOCK: begin
        lo_raw = blk_lo_i;
        hi_raw = blk_hi_i;
      end
      default: begin
        lo_raw = guard ? BOOT_NEXT : '0;
        hi_raw = '1;
      end
    endcase
    if (op_i != OP_CHIP && guard && in_boot_i)
      accept_o = 1'b0;
    lo_o = accept_o ? lo_raw : '0;
    hi_o = accept_o ? hi_raw : '0;
  end
endmodule

// File: rtl/bootlock_guard.sv
module bootlock_guard
  import bootlock_pkg::*;
#(
  parameter int ADDR_W  = 18,
  parameter int PAGE_W  = 11,
  parameter int BOOT_W  = 13,
  parameter int PARAM_W = 12,
  parameter int MID_W   = 14,
  parameter int MAIN_W  = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              por,
  input  logic              req_valid_i,
  input  logic [1:0]        req_op_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              lock_set_i,
  input  logic              hv_override_i,
  output logic              done_o,
  output logic              accept_o,
  output logic [ADDR_W-1:0] range_start_o,
  output logic [ADDR_W-1:0] range_end_o,
  output logic              lock_status_o
);
  logic [ADDR_W-1:0] page_lo, page_hi, blk_lo, blk_hi;
  logic [ADDR_W-1:0] g_lo, g_hi;
  logic              in_boot, g_acc, locked;

  bl_lock_flag u_flag (
    .clk      (clk),
    .por      (por),
    .rst      (rst),
    .set_i    (lock_set_i),
    .locked_o (locked)
  );

  bl_region_map #(
    .ADDR_W (ADDR_W), .PAGE_W (PAGE_W), .BOOT_W (BOOT_W),
    .PARAM_W(PARAM_W), .MID_W (MID_W), .MAIN_W (MAIN_W)
  ) u_map (
    .addr_i    (req_addr_i),
    .page_lo_o (page_lo),
    .page_hi_o (page_hi),
    .blk_lo_o  (blk_lo),
    .blk_hi_o  (blk_hi),
    .in_boot_o (in_boot)
  );

  bl_gate #(.ADDR_W(ADDR_W), .BOOT_W(BOOT_W)) u_gate (
    .op_i      (op_e'(req_op_i)),
    .addr_i    (req_addr_i),
    .locked_i  (locked),
    .hv_i      (hv_override_i),
    .page_lo_i (page_lo),
    .page_hi_i (page_hi),
    .blk_lo_i  (blk_lo),
    .blk_hi_i  (blk_hi),
    .in_boot_i (in_boot),
    .accept_o  (g_acc),
    .lo_o      (g_lo),
    .hi_o      (g_hi)
  );

  always_ff @(posedge clk) begin
    if (rst || por) begin
      done_o        <= 1'b0;
      accept_o      <= 1'b0;
      range_start_o <= '0;
      range_end_o   <= '0;
    end else begin
      done_o        <= req_valid_i;
      accept_o      <= req_valid_i && g_acc;
      range_start_o <= req_valid_i ? g_lo : '0;
      range_end_o   <= req_valid_i ? g_hi : '0;
    end
  end

  assign lock_status_o = locked;
endmodule

// File: rtl/bootlock_guard_chk.sv
module bootlock_guard_chk #(
  parameter int ADDR_W = 18,
  parameter int BOOT_W = 13
) (
  input logic              clk,
  input logic              rst,
  input logic              por,
  input logic              req_valid_i,
  input logic [1:0]        req_op_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic              hv_override_i,
  input logic              done_o,
  input logic              accept_o,
  input logic [ADDR_W-1:0] range_start_o,
  input logic [ADDR_W-1:0] range_end_o,
  input logic              lock_status_o
);
  logic boot_hit;
  assign boot_hit = (req_addr_i[ADDR_W-1:BOOT_W] == '0);

  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (por)
    rst |=> (!done_o && !accept_o));

  a_r2_lock_sticky: assert property (@(posedge clk)
    (lock_status_o && !por) |=> lock_status_o);

  a_r3_range_order: assert property (@(posedge clk) disable iff (por || rst)
    accept_o |-> (range_start_o <= range_end_o));

  a_r6_boot_drop: assert property (@(posedge clk) disable iff (por)
    (req_valid_i && !rst && lock_status_o && !hv_override_i &&
     req_op_i != 2'd3 && boot_hit) |=> (done_o && !accept_o));

  a_r7_chip_top: assert property (@(posedge clk) disable iff (por)
    (req_valid_i && !rst && req_op_i == 2'd3) |=> (accept_o && range_end_o == '1));

  a_r10_done_follows: assert property (@(posedge clk) disable iff (por)
    (req_valid_i && !rst) |=> done_o);

  a_r10_no_spurious: assert property (@(posedge clk) disable iff (por)
    !(req_valid_i && !rst) |=> !done_o);
endmodule

bind bootlock_guard bootlock_guard_chk #(.ADDR_W(ADDR_W), .BOOT_W(BOOT_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .por           (por),
  .req_valid_i   (req_valid_i),
  .req_op_i      (req_op_i),
  .req_addr_i    (req_addr_i),
  .hv_override_i (hv_override_i),
  .done_o        (done_o),
  .accept_o      (accept_o),
  .range_start_o (range_start_o),
  .range_end_o   (range_end_o),
  .lock_status_o (lock_status_o)
);

// File: tb/bootlock_guard_test.sv
module bootlock_guard_test;
  logic        clk = 1'b0;
  logic        rst, por, req_valid_i, lock_set_i, hv_override_i;
  logic [1:0]  req_op_i;
  logic [17:0] req_addr_i;
  logic        done_o, accept_o, lock_status_o;
  logic [17:0] range_start_o, range_end_o;

  int checks = 0;
  int errors = 0;
  bit m_lock = 1'b0;

  always #10 clk = ~clk;

  bootlock_guard uut (
    .clk(clk), .rst(rst), .por(por), .req_valid_i(req_valid_i),
    .req_op_i(req_op_i), .req_addr_i(req_addr_i), .lock_set_i(lock_set_i),
    .hv_override_i(hv_override_i), .done_o(done_o), .accept_o(accept_o),
    .range_start_o(range_start_o), .range_end_o(range_end_o),
    .lock_status_o(lock_status_o)
  );

  // Behavioural reference for one request.
  function automatic void model(input int op, input int addr, input bit lk, input bit hv,
                                output bit acc, output int lo, output int hi);
    bit guard = lk && !hv;
    acc = 1'b1;
    case (op)
      0: begin lo = addr; hi = addr; end
      1: begin lo = (addr / 2048) * 2048; hi = lo + 2047; end
      2: begin
        if (addr < 'h2000)      begin lo = 0;       hi = 'h1FFF; end
        else if (addr < 'h3000) begin lo = 'h2000;  hi = 'h2FFF; end
        else if (addr < 'h4000) begin lo = 'h3000;  hi = 'h3FFF; end
        else if (addr < 'h8000) begin lo = 'h4000;  hi = 'h7FFF; end
        else begin lo = (addr / 'h8000) * 'h8000;   hi = lo + 'h7FFF; end
      end
      default: begin lo = guard ? 'h2000 : 0; hi = 'h3FFFF; end
    endcase
    if (op != 3 && guard && addr < 'h2000) begin
      acc = 1'b0; lo = 0; hi = 0;
    end
  endfunction

  task automatic step(input string tag, input bit v, input int op, input int addr,
                      input bit ls = 0, input bit hv = 0, input bit r = 0, input bit p = 0);
    bit e_done, e_acc, a;
    int e_lo, e_hi, l, h;
    rst = r; por = p; req_valid_i = v; req_op_i = op[1:0];
    req_addr_i = addr[17:0]; lock_set_i = ls; hv_override_i = hv;
    e_done = 0; e_acc = 0; e_lo = 0; e_hi = 0;
    if (!r && !p && v) begin
      model(op, addr, m_lock, hv, a, l, h);
      e_done = 1; e_acc = a; e_lo = l; e_hi = h;
    end
    if (p) m_lock = 0;
    else if (ls && !r) m_lock = 1;
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (done_o !== e_done || accept_o !== e_acc || int'(range_start_o) != e_lo ||
        int'(range_end_o) != e_hi || lock_status_o !== m_lock) begin
      errors++;
      $display("FAIL %s: got done=%0b acc=%0b lo=%h hi=%h lock=%0b, expected done=%0b acc=%0b lo=%h hi=%h lock=%0b",
               tag, done_o, accept_o, range_start_o, range_end_o, lock_status_o,
               e_done, e_acc, e_lo[17:0], e_hi[17:0], m_lock);
    end
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 0; por = 1; req_valid_i = 0; req_op_i = 0; req_addr_i = 0;
    lock_set_i = 0; hv_override_i = 0;
    @(negedge clk);
    step("R1", 1, 0, 'h10, 0, 0, 0, 1);
    step("R1", 1, 3, 0, 1, 0, 1, 0);           // request and strobe both under rst
    step("R2", 0, 0, 0);
    // Unlocked functions
    step("R3", 1, 0, 'h00010);
    step("R4", 1, 1, 'h01234);
    step("R4", 1, 1, 'h3FFFF);
    step("R5", 1, 2, 'h00123);
    step("R5", 1, 2, 'h02ABC);
    step("R5", 1, 2, 'h03FFF);
    step("R5", 1, 2, 'h05000);
    step("R5", 1, 2, 'h2A123);
    step("R5", 1, 2, 'h08000);
    step("R7", 1, 3, 'h00000);
    step("R10", 0, 0, 0);
    // Set lock together with a boot request: judged on old flag
    step("R9", 1, 0, 'h00100, 1);
    step("R6", 1, 0, 'h00100);
    step("R6", 1, 1, 'h01800);
    step("R6", 1, 2, 'h00000);
    step("R6", 1, 0, 'h01FFF);
    step("R6", 1, 0, 'h02000);
    step("R6", 1, 1, 'h02000);
    step("R7", 1, 3, 'h00000);
    // Override only while held
    step("R8", 1, 0, 'h00100, 0, 1);
    step("R8", 1, 3, 'h00000, 0, 1);
    step("R8", 1, 2, 'h00500, 0, 1);
    step("R8", 1, 0, 'h00100, 0, 0);
    // Lock survives rst, cleared by por
    step("R2", 0, 0, 0, 0, 0, 1);
    step("R2", 1, 1, 'h00000);
    step("R2", 0, 0, 0, 0, 0, 0, 1);
    step("R2", 1, 1, 'h00000);
    step("R10", 0, 0, 0);
    step("R2", 0, 0, 0, 1);
    step("R6", 1, 2, 'h01000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule